// File: doc/BRIEF.md
# Serial-Load DAC Input Register

This block is the digital input stage of a 16-bit current-output converter. A host writes a code over a three-wire link made of a serial clock, a serial data line and an active-low select. While the select is low, every rising serial-clock edge pushes one data bit into a shift register, most significant bit first. When the select returns high, the shift register is copied into a parallel holding register that drives the converter core.

A frame may carry any number of bits. Only the last sixteen clocked in are kept, so extra leading bits fall out of the top of the register. A frame with fewer than sixteen clocks still loads. The new bits then occupy the low positions and bits left from earlier frames sit above them. The block runs on a system clock. The three link pins pass through a configurable synchronizer and edge detectors, so the serial clock has to be slow compared with the system clock. A one-cycle strobe marks every load of the holding register.

Top module: `dac_ser_load`

## Requirements
- R1: During and after reset the holding register output is 0x0000, the update strobe is low and the shift register holds 0x0000.
- R2: A data bit is taken only on a rising edge of the serial clock. A change on the data line while the serial clock is high, followed by a falling edge, does not alter the captured bit.
- R3: Bits enter most significant first: in a 16-bit frame, the first bit sent appears at output bit 15 and the last at bit 0.
- R4: When a frame carries more than 16 clocks, only the final 16 bits reach the output.
- R5: When a frame carries fewer than 16 clocks, the n new bits occupy output bits n-1..0 and bits 15..n hold the shift contents left from before the frame (0 after reset).
- R6: Serial-clock edges while the select is high leave the shift register unchanged, so a following frame with no clocks loads the same code as before.
- R7: The holding register output changes only in the cycle after a select rising edge is detected, and stays stable at all other times.
- R8: The update strobe is high for exactly one system-clock cycle per select rising edge, in the same cycle the new code appears on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host, asynchronous |
| ser_sel_n | input | 1 | Active-low frame select, asynchronous |
| ser_din | input | 1 | Serial data, most significant bit first |
| dac_code | output | CODE_W (16) | Parallel holding register driving the converter |
| code_upd | output | 1 | One-cycle strobe on each holding register load |

## Verification
The bench sends frames of zero, four, eight, sixteen, twenty and forty clocks and compares each loaded code with an independent model of the shift contents. A design that kept the first sixteen bits instead of the last would fail the long frames. One that cleared the register at frame start would put zeros above a short frame where older bits belong. One that sampled on the falling edge would pick up the inverted bit the bench puts on the data line while the clock is high. Idle clocks with the select high, followed by an empty frame, reveal any shifting outside a frame. The strobe is watched for double pulses and for code changes that occur without it.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;

   // bit positions of the link pins inside the synchronizer bus
   localparam int PIN_CLK  = 0;
   localparam int PIN_SEL  = 1;
   localparam int PIN_DIN  = 2;
   localparam int PIN_CNT  = 3;

   // idle level of the link pins seen at reset: select released, clock and data low
   localparam logic [PIN_CNT-1:0] PIN_IDLE = 3'b010;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_sel_e;

endpackage

// File: rtl/dac_ser_sync.sv
module dac_ser_sync #(
   parameter int              W       = 3,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_chk_w
      $error("dac_ser_sync: W must be at least 1");
   end
   if (STAGES < 0 || STAGES > 4) begin : g_chk_st
      $error("dac_ser_sync: STAGES must be 0 to 4");
   end

   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_chain
      logic [W-1:0] stg_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_q[0] <= RST_VAL;
         end else begin
            stg_q[0] <= d_i;
         end
      end

      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_q[i] <= RST_VAL;
            end else begin
               stg_q[i] <= stg_q[i-1];
            end
         end
      end

      assign q_o = stg_q[STAGES-1];
   end

endmodule

// File: rtl/dac_ser_edge.sv
module dac_ser_edge
   import dac_ser_pkg::*;
#(
   parameter edge_sel_e KIND    = EDGE_RISE,
   parameter logic      RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic hit_o
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= RST_VAL;
      end else begin
         prev_q <= lvl_i;
      end
   end

   if (KIND == EDGE_RISE) begin : g_rise
      assign hit_o = lvl_i & ~prev_q;
   end else begin : g_fall
      assign hit_o = ~lvl_i & prev_q;
   end

   // an edge can never be reported in two consecutive cycles
   a_r8_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> !hit_o);

endmodule

// File: rtl/dac_ser_shifter.sv
module dac_ser_shifter #(
   parameter int CODE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_rise_i,
   input  logic              sel_n_i,
   input  logic              din_i,
   output logic [CODE_W-1:0] sh_o
);

   if (CODE_W < 2) begin : g_chk_w
      $error("dac_ser_shifter: CODE_W must be at least 2");
   end

   logic              shift_en;
   logic [CODE_W-1:0] sh_q;

   assign shift_en = sclk_rise_i & ~sel_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (shift_en) begin
         sh_q <= {sh_q[CODE_W-2:0], din_i};
      end
   end

   assign sh_o = sh_q;

   // R6: select released means no movement of the shift contents
   a_r6_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n_i |=> $stable(sh_q));

   // R3: each accepted bit lands at bit 0 and older bits move up by one
   a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_rise_i && !sel_n_i) |=>
         (sh_q[0] == $past(din_i)) && (sh_q[CODE_W-1:1] == $past(sh_q[CODE_W-2:0])));

   // R2: without a rising serial-clock edge nothing is captured
   a_r2_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise_i |=> $stable(sh_q));

endmodule

// File: rtl/dac_ser_hold.sv
module dac_ser_hold #(
   parameter int CODE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CODE_W-1:0] sh_i,
   output logic [CODE_W-1:0] code_o,
   output logic              upd_o
);

   logic [CODE_W-1:0] code_q;
   logic              upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= load_i;
         if (load_i) begin
            code_q <= sh_i;
         end
      end
   end

   assign code_o = code_q;
   assign upd_o  = upd_q;

   // R7: the output moves only after a load request
   a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(code_q));

   // R8: load request gives the strobe and the shift contents together
   a_r8_upd_with_code: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (upd_q && code_q == $past(sh_i)));

   // R8: strobe lasts one cycle
   a_r8_upd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |=> !upd_q);

endmodule

// File: rtl/dac_ser_load.sv
module dac_ser_load
   import dac_ser_pkg::*;
#(
   parameter int CODE_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_sel_n,
   input  logic              ser_din,
   output logic [CODE_W-1:0] dac_code,
   output logic              code_upd
);

   logic [PIN_CNT-1:0] pins_raw;
   logic [PIN_CNT-1:0] pins_sync;
   logic               sclk_rise;
   logic               sel_rise;
   logic [CODE_W-1:0]  sh_val;

   assign pins_raw[PIN_CLK] = ser_clk;
   assign pins_raw[PIN_SEL] = ser_sel_n;
   assign pins_raw[PIN_DIN] = ser_din;

   dac_ser_sync #(
      .W       (PIN_CNT),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_raw),
      .q_o   (pins_sync)
   );

   dac_ser_edge #(
      .KIND    (EDGE_RISE),
      .RST_VAL (PIN_IDLE[PIN_CLK])
   ) u_sclk_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (pins_sync[PIN_CLK]),
      .hit_o (sclk_rise)
   );

   dac_ser_edge #(
      .KIND    (EDGE_RISE),
      .RST_VAL (PIN_IDLE[PIN_SEL])
   ) u_sel_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (pins_sync[PIN_SEL]),
      .hit_o (sel_rise)
   );

   dac_ser_shifter #(
      .CODE_W (CODE_W)
   ) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_rise_i (sclk_rise),
      .sel_n_i     (pins_sync[PIN_SEL]),
      .din_i       (pins_sync[PIN_DIN]),
      .sh_o        (sh_val)
   );

   dac_ser_hold #(
      .CODE_W (CODE_W)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (sel_rise),
      .sh_i   (sh_val),
      .code_o (dac_code),
      .upd_o  (code_upd)
   );

   // R1: while reset is held the outputs sit at their cleared values
   always_comb begin
      if (!rst_n) begin
         a_r1_reset_clear: assert (dac_code == '0 && code_upd == 1'b0);
      end
   end

endmodule

// File: tb/sim_dac_ser_load.sv
module sim_dac_ser_load;

   localparam int CLK_PERIOD = 10;
   localparam int CODE_W     = 16;
   localparam int HALF       = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ser_clk = 1'b0;
   logic              ser_sel_n = 1'b1;
   logic              ser_din = 1'b0;
   logic [CODE_W-1:0] dac_code;
   logic              code_upd;

   int n_vec  = 0;
   int n_fail = 0;
   int n_upd  = 0;
   int n_frm  = 0;
   bit done   = 1'b0;

   logic [CODE_W-1:0] model_sh = '0;
   logic [CODE_W-1:0] exp_q[$];
   string             tag_q[$];
   logic [CODE_W-1:0] last_code = '0;
   logic              last_upd  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dac_ser_load #(.CODE_W(CODE_W), .SYNC_STAGES(2)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_clk   (ser_clk),
      .ser_sel_n (ser_sel_n),
      .ser_din   (ser_din),
      .dac_code  (dac_code),
      .code_upd  (code_upd)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // drives one frame; bits[n-1] goes first. glitch puts the inverted bit on
   // the data line while the serial clock is high (R2)
   task automatic send_frame(input logic [63:0] bits, input int n,
                             input bit glitch, input string tag);
      ser_sel_n = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < n; i++) begin
         ser_din = bits[n-1-i];
         wait_clk(HALF);
         ser_clk  = 1'b1;
         model_sh = {model_sh[CODE_W-2:0], bits[n-1-i]};
         wait_clk(HALF/2);
         if (glitch) ser_din = ~bits[n-1-i];
         wait_clk(HALF - HALF/2);
         ser_clk = 1'b0;
      end
      wait_clk(HALF);
      exp_q.push_back(model_sh);
      tag_q.push_back(tag);
      n_frm++;
      ser_sel_n = 1'b1;
      wait_clk(4*HALF);
   endtask

   // serial clocks with the select released (R6)
   task automatic idle_clocks(input int n);
      for (int i = 0; i < n; i++) begin
         ser_din = ~ser_din;
         wait_clk(HALF);
         ser_clk = 1'b1;
         wait_clk(HALF);
         ser_clk = 1'b0;
      end
      wait_clk(HALF);
   endtask

   // monitor: pops expected codes as strobes appear
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (code_upd) begin
            n_upd++;
            n_vec++;
            if (last_upd) begin
               n_fail++;
               $display("FAIL R8: strobe high two cycles, actual=1 expected=0");
            end
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL R8: unexpected strobe, actual code=%h expected=none", dac_code);
            end else begin
               logic [CODE_W-1:0] e;
               string             t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (dac_code !== e) begin
                  n_fail++;
                  $display("FAIL %s: loaded code actual=%h expected=%h", t, dac_code, e);
               end
            end
         end else if (dac_code !== last_code) begin
            n_fail++;
            $display("FAIL R7: code changed without strobe, actual=%h expected=%h",
                     dac_code, last_code);
         end
         last_code = dac_code;
         last_upd  = code_upd;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      wait_clk(5);
      // R1: cleared outputs while in reset
      n_vec++;
      if (dac_code !== '0 || code_upd !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: reset outputs actual=%h/%b expected=0000/0", dac_code, code_upd);
      end
      rst_n = 1'b1;
      wait_clk(5);
      n_vec++;
      if (dac_code !== '0 || code_upd !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: after reset actual=%h/%b expected=0000/0", dac_code, code_upd);
      end

      // R1 R5: short frame after reset, upper bits must be zero -> 000B
      send_frame(64'hB, 4, 1'b0, "R5");
      // R3: full frames, first bit to bit 15
      send_frame(64'hA5C3, 16, 1'b0, "R3");
      send_frame(64'h8001, 16, 1'b0, "R3");
      // R2: inverted data while the clock is high must not be taken
      send_frame(64'h3C96, 16, 1'b1, "R2");
      send_frame(64'h8001, 16, 1'b0, "R3");
      // R6: clocks with select high, then an empty frame reloads 8001
      idle_clocks(7);
      send_frame(64'h0, 0, 1'b0, "R6");
      // R4: long frames keep only the last 16 bits
      send_frame(64'hF1234, 20, 1'b0, "R4");
      send_frame(64'hDEAD_BEEF_CAFE, 40, 1'b0, "R4");
      // R5: short frame keeps older bits above the new ones
      send_frame(64'h5A, 8, 1'b0, "R5");
      send_frame(64'h1, 1, 1'b0, "R5");
      send_frame(64'hFFFF, 16, 1'b0, "R3");
      send_frame(64'h0000, 16, 1'b1, "R2");
      idle_clocks(3);
      send_frame(64'h6, 3, 1'b0, "R6");

      wait_clk(20);
      done = 1'b1;
      // R8: one strobe per frame, every expected code consumed
      n_vec++;
      if (n_upd != n_frm || exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R8: strobes actual=%0d expected=%0d", n_upd, n_frm);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule